// File: doc/BRIEF.md
# Saturating Output Shifter with Fraction and Address Latches

This block is the output stage of a step-sequenced audio effect datapath. On each step it takes the accumulator result that the multiply-add stage delivered one step earlier and scales it to a 24-bit value. The scaling mode selects a right shift of one or two places. It also selects whether the result is clamped to a 20-bit signed range or simply wrapped to 24 bits. The scaled value feeds three consumers: a write port into a 128-entry temporary ring, a bank of sixteen effect-output accumulators, and two small latches. One latch holds a fraction for the multiplier's Y operand. The other holds an offset for the memory address generator.

A sequencer pulses `step_i` once per program step and drives that step's control bits alongside it. `frame_i` clears every effect accumulator at the start of a sample frame. The multiplier, the ring storage itself and the external memory path sit outside this block.

Top module: `out_shift_stage`

## Requirements
- R1: While `rst_ni` is low, `temp_we_o`, `temp_waddr_o`, `temp_wdata_o`, `frc_o`, `adrs_o` and all of `eff_regs_o` are zero.
- R2: `acc_i` is captured only on cycles with `step_i` high, and the capture starts at reset as zero. A step's outputs are computed from the value captured at the previous step, not from `acc_i` of the same step. All registered outputs appear in the cycle after the step edge.
- R3: With `shift_mode_i` = 2'b00, the result is the accumulator arithmetically shifted right by 2 and clamped to [-0x80000, 0x7FFFF].
- R4: With `shift_mode_i` = 2'b01, the result is the accumulator arithmetically shifted right by 1 and clamped to [-0x80000, 0x7FFFF].
- R5: With `shift_mode_i` = 2'b10, the result is the low 24 bits of the accumulator arithmetically shifted right by 1, with no clamping.
- R6: With `shift_mode_i` = 2'b11, the result is the low 24 bits of the accumulator arithmetically shifted right by 2, with no clamping.
- R7: When a step has `frc_ld_i` high, the 13-bit `frc_o` loads as follows. In mode 2'b11 it takes result bits [11:0], zero-extended. In every other mode it takes result bits [23:11].
- R8: When a step has `adrs_ld_i` high, the 16-bit `adrs_o` loads as follows. In mode 2'b11 it takes result bits [23:12], zero-extended. In every other mode it takes `bus_i[31:16]`.
- R9: On every step, `temp_wdata_o` takes the result and `temp_waddr_o` takes (`temp_ofs_i` + `ring_ct_i`) mod 128. `temp_we_o` is high only in the cycle after a step with `temp_wr_i` high.
- R10: When a step has `eff_wr_i` high, entry `eff_sel_i` of the effect bank (bits [24k+23:24k] of `eff_regs_o`) adds the result arithmetically shifted right by 4. The addition is sign-extended and wraps at 24 bits. The other entries are unchanged.
- R11: `frame_i` clears all sixteen entries on any cycle. If the same cycle also carries an effect write, the selected entry becomes the added term alone.
- R12: On cycles with `step_i` low, `temp_we_o` is low. The latches, the effect entries (unless `frame_i` is high), the ring write data and the captured accumulator all hold, whatever the control inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Program step strobe |
| frame_i | input | 1 | Clear all effect accumulators |
| acc_i | input | 26 | Signed accumulator from the multiply-add stage |
| shift_mode_i | input | 2 | Scaling mode (see R3 to R6) |
| frc_ld_i | input | 1 | Load fraction latch this step |
| adrs_ld_i | input | 1 | Load address-offset latch this step |
| temp_wr_i | input | 1 | Write the result into the temporary ring this step |
| eff_wr_i | input | 1 | Accumulate into an effect entry this step |
| temp_ofs_i | input | 7 | Ring write offset |
| eff_sel_i | input | 4 | Effect entry index |
| bus_i | input | 32 | Input-bus value used by the address latch |
| ring_ct_i | input | 16 | Ring rotation count, added to the ring offset |
| temp_we_o | output | 1 | Ring write enable |
| temp_waddr_o | output | 7 | Ring write address |
| temp_wdata_o | output | 24 | Ring write data (the scaled result) |
| frc_o | output | 13 | Fraction latch |
| adrs_o | output | 16 | Address-offset latch |
| eff_regs_o | output | 384 | Sixteen 24-bit effect accumulators, entry k at bits [24k+23:24k] |

## Verification
Every result of a step is due in the cycle after that step's clock edge: the ring port, the latches and the effect entries. The scaled value inside those results comes from the accumulator captured one step earlier, so its effect is delayed by one full step, however many idle cycles lie between. The driver pushes one expected record per driven cycle. It computes that record from a model that keeps its own copy of the previous step's accumulator. The monitor pops the record at the falling edge right after the next rising edge, when every registered output has settled. Idle cycles push records too, so holding behaviour and the frame clear are checked in the very cycle they take effect.

// File: rtl/osh_pkg.sv
package osh_pkg;
  typedef enum logic [1:0] {
    SH_SAT_R2  = 2'b00,
    SH_SAT_R1  = 2'b01,
    SH_WRAP_R1 = 2'b10,
    SH_WRAP_R2 = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/osh_shifter.sv
module osh_shifter #(
  parameter int ACC_W = 26,
  parameter int OUT_W = 24,
  parameter int SAT_W = 20
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  osh_pkg::shift_mode_e    mode_i,
  output logic        [OUT_W-1:0] res_o
);
  localparam logic signed [ACC_W-1:0] LIM_HI = ACC_W'((64'sd1 <<< (SAT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] LIM_LO = -LIM_HI - ACC_W'(1);

  logic signed [ACC_W-1:0] pre, clamped;
  logic one_place;

  always_comb begin
    one_place = (mode_i == osh_pkg::SH_SAT_R1) || (mode_i == osh_pkg::SH_WRAP_R1);
    pre       = one_place ? (acc_i >>> 1) : (acc_i >>> 2);
    clamped   = pre;
    if (pre > LIM_HI)      clamped = LIM_HI;
    else if (pre < LIM_LO) clamped = LIM_LO;
    // upper mode bit selects wrap instead of clamp
    res_o = mode_i[1] ? pre[OUT_W-1:0] : clamped[OUT_W-1:0];
  end
endmodule

// File: rtl/osh_latches.sv
module osh_latches #(
  parameter int OUT_W  = 24,
  parameter int FRC_W  = 13,
  parameter int ADRS_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              frc_ld_i,
  input  logic              adrs_ld_i,
  input  logic              narrow_i,
  input  logic [OUT_W-1:0]  res_i,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [FRC_W-1:0]  frc_o,
  output logic [ADRS_W-1:0] adrs_o
);
  localparam int FRC_LO_W = FRC_W - 1;
  localparam int ADR_FW   = OUT_W / 2;

  logic [FRC_W-1:0]  frc_d;
  logic [ADRS_W-1:0] adrs_d;

  always_comb begin
    frc_d  = narrow_i ? FRC_W'(res_i[FRC_LO_W-1:0]) : res_i[OUT_W-1 -: FRC_W];
    adrs_d = narrow_i ? ADRS_W'(res_i[OUT_W-1 -: ADR_FW]) : bus_i[BUS_W-1 -: ADRS_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frc_o  <= '0;
      adrs_o <= '0;
    end else if (step_i) begin
      if (frc_ld_i)  frc_o  <= frc_d;
      if (adrs_ld_i) adrs_o <= adrs_d;
    end
  end
endmodule

// File: rtl/osh_eff_bank.sv
module osh_eff_bank #(
  parameter int N     = 16,
  parameter int W     = 24,
  parameter int IN_W  = 24,
  parameter int SHR   = 4,
  localparam int SEL_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IN_W-1:0]  val_i,
  output logic [N*W-1:0]   regs_o
);
  logic signed [IN_W-1:0] scaled;
  logic signed [W-1:0]    inc;

  assign scaled = $signed(val_i) >>> SHR;
  assign inc    = W'(scaled);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [W-1:0] q;
    logic [W-1:0] base;
    assign base = clr_i ? '0 : q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (add_i && sel_i == SEL_W'(g))   q <= base + inc;
      else if (clr_i)                         q <= '0;
    end
    assign regs_o[g*W +: W] = q;
  end
endmodule

// File: rtl/out_shift_stage.sv
module out_shift_stage #(
  parameter int ACC_W      = 26,
  parameter int OUT_W      = 24,
  parameter int SAT_W      = 20,
  parameter int FRC_W      = 13,
  parameter int ADRS_W     = 16,
  parameter int BUS_W      = 32,
  parameter int CT_W       = 16,
  parameter int TEMP_DEPTH = 128,
  parameter int EFF_N      = 16,
  parameter int EFF_W      = 24,
  parameter int EFF_SHR    = 4,
  localparam int TA_W      = $clog2(TEMP_DEPTH),
  localparam int ES_W      = $clog2(EFF_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic                   frame_i,
  input  logic [ACC_W-1:0]       acc_i,
  input  logic [1:0]             shift_mode_i,
  input  logic                   frc_ld_i,
  input  logic                   adrs_ld_i,
  input  logic                   temp_wr_i,
  input  logic                   eff_wr_i,
  input  logic [TA_W-1:0]        temp_ofs_i,
  input  logic [ES_W-1:0]        eff_sel_i,
  input  logic [BUS_W-1:0]       bus_i,
  input  logic [CT_W-1:0]        ring_ct_i,
  output logic                   temp_we_o,
  output logic [TA_W-1:0]        temp_waddr_o,
  output logic [OUT_W-1:0]       temp_wdata_o,
  output logic [FRC_W-1:0]       frc_o,
  output logic [ADRS_W-1:0]      adrs_o,
  output logic [EFF_N*EFF_W-1:0] eff_regs_o
);
  osh_pkg::shift_mode_e mode;
  logic [ACC_W-1:0] acc_q;
  logic [OUT_W-1:0] res;

  assign mode = osh_pkg::shift_mode_e'(shift_mode_i);

  // previous step's accumulator feeds this step's shifter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= acc_i;
  end

  osh_shifter #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SAT_W(SAT_W)) u_shift (
    .acc_i  ($signed(acc_q)),
    .mode_i (mode),
    .res_o  (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_we_o    <= 1'b0;
      temp_waddr_o <= '0;
      temp_wdata_o <= '0;
    end else begin
      temp_we_o <= step_i && temp_wr_i;
      if (step_i) begin
        temp_waddr_o <= temp_ofs_i + ring_ct_i[TA_W-1:0];
        temp_wdata_o <= res;
      end
    end
  end

  osh_latches #(.OUT_W(OUT_W), .FRC_W(FRC_W), .ADRS_W(ADRS_W), .BUS_W(BUS_W)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .frc_ld_i  (frc_ld_i),
    .adrs_ld_i (adrs_ld_i),
    .narrow_i  (mode == osh_pkg::SH_WRAP_R2),
    .res_i     (res),
    .bus_i     (bus_i),
    .frc_o     (frc_o),
    .adrs_o    (adrs_o)
  );

  osh_eff_bank #(.N(EFF_N), .W(EFF_W), .IN_W(OUT_W), .SHR(EFF_SHR)) u_eff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_i),
    .add_i  (step_i && eff_wr_i),
    .sel_i  (eff_sel_i),
    .val_i  (res),
    .regs_o (eff_regs_o)
  );
endmodule

// File: rtl/out_shift_stage_chk.sv
module out_shift_stage_chk #(
  parameter int OUT_W  = 24,
  parameter int SAT_W  = 20,
  parameter int FRC_W  = 13,
  parameter int ADRS_W = 16,
  parameter int CT_W   = 16,
  parameter int TA_W   = 7,
  parameter int ES_W   = 4,
  parameter int EFF_N  = 16,
  parameter int EFF_W  = 24
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   step_i,
  input logic                   frame_i,
  input logic [1:0]             shift_mode_i,
  input logic                   frc_ld_i,
  input logic                   adrs_ld_i,
  input logic                   temp_wr_i,
  input logic                   eff_wr_i,
  input logic [TA_W-1:0]        temp_ofs_i,
  input logic [CT_W-1:0]        ring_ct_i,
  input logic                   temp_we_o,
  input logic [TA_W-1:0]        temp_waddr_o,
  input logic [OUT_W-1:0]       temp_wdata_o,
  input logic [FRC_W-1:0]       frc_o,
  input logic [ADRS_W-1:0]      adrs_o,
  input logic [EFF_N*EFF_W-1:0] eff_regs_o
);
  localparam logic signed [OUT_W-1:0] HI = OUT_W'((64'sd1 <<< (SAT_W-1)) - 64'sd1);
  localparam logic signed [OUT_W-1:0] LO = -HI - OUT_W'(1);

  AST_WE_FROM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_we_o |-> $past(step_i && temp_wr_i)); // R9

  AST_WADDR_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_we_o |-> temp_waddr_o == TA_W'($past(temp_ofs_i) + $past(ring_ct_i[TA_W-1:0]))); // R9

  AST_CLAMP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_i && !shift_mode_i[1]) |->
      ($signed(temp_wdata_o) <= HI) && ($signed(temp_wdata_o) >= LO)); // R3

  AST_FRC_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_i && frc_ld_i && shift_mode_i == 2'b11) |-> !frc_o[FRC_W-1]); // R7

  AST_FRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_i && frc_ld_i) |-> $stable(frc_o)); // R12

  AST_ADRS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_i && adrs_ld_i) |-> $stable(adrs_o)); // R12

  AST_FRAME_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_i && !(step_i && eff_wr_i)) |-> eff_regs_o == '0); // R11

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_i) |-> $stable(temp_wdata_o)); // R12
endmodule

bind out_shift_stage out_shift_stage_chk #(
  .OUT_W(OUT_W), .SAT_W(SAT_W), .FRC_W(FRC_W), .ADRS_W(ADRS_W), .CT_W(CT_W),
  .TA_W(TA_W), .ES_W(ES_W), .EFF_N(EFF_N), .EFF_W(EFF_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .frame_i(frame_i),
  .shift_mode_i(shift_mode_i), .frc_ld_i(frc_ld_i), .adrs_ld_i(adrs_ld_i),
  .temp_wr_i(temp_wr_i), .eff_wr_i(eff_wr_i), .temp_ofs_i(temp_ofs_i),
  .ring_ct_i(ring_ct_i), .temp_we_o(temp_we_o), .temp_waddr_o(temp_waddr_o),
  .temp_wdata_o(temp_wdata_o), .frc_o(frc_o), .adrs_o(adrs_o), .eff_regs_o(eff_regs_o)
);

// File: tb/out_shift_stage_tb_top.sv
module out_shift_stage_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         step_i = 1'b0, frame_i = 1'b0;
  logic [25:0]  acc_i = '0;
  logic [1:0]   shift_mode_i = '0;
  logic         frc_ld_i = 1'b0, adrs_ld_i = 1'b0, temp_wr_i = 1'b0, eff_wr_i = 1'b0;
  logic [6:0]   temp_ofs_i = '0;
  logic [3:0]   eff_sel_i = '0;
  logic [31:0]  bus_i = '0;
  logic [15:0]  ring_ct_i = '0;
  logic         temp_we_o;
  logic [6:0]   temp_waddr_o;
  logic [23:0]  temp_wdata_o;
  logic [12:0]  frc_o;
  logic [15:0]  adrs_o;
  logic [383:0] eff_regs_o;

  always #5 clk_i = ~clk_i;

  out_shift_stage dut_i (.*);

  typedef struct {
    logic         we;
    logic [6:0]   addr;
    logic [23:0]  data;
    logic [12:0]  frc;
    logic [15:0]  adrs;
    logic [383:0] eff;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [25:0] m_acc = '0;
  logic [6:0]  m_addr = '0;
  logic [23:0] m_data = '0;
  logic [12:0] m_frc = '0;
  logic [15:0] m_adrs = '0;
  logic [23:0] m_eff [16];

  function automatic logic [23:0] ref_shift(logic [25:0] a, logic [1:0] md);
    longint v = longint'($signed(a));
    v = (md == 2'b01 || md == 2'b10) ? (v >>> 1) : (v >>> 2);
    if (md[1] == 1'b0) begin
      if (v > 524287)  v = 524287;
      if (v < -524288) v = -524288;
    end
    return v[23:0];
  endfunction

  task automatic chk(string tag, string what, logic [383:0] act, logic [383:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(bit stp, bit frm, logic [25:0] acc, logic [1:0] md, bit fl, bit al,
                       bit tw, bit ew, logic [6:0] to, logic [3:0] es, logic [31:0] bus,
                       logic [15:0] ct, string tag);
    exp_t e;
    logic [23:0] sh;
    longint inc;
    @(negedge clk_i);
    step_i = stp; frame_i = frm; acc_i = acc; shift_mode_i = md; frc_ld_i = fl;
    adrs_ld_i = al; temp_wr_i = tw; eff_wr_i = ew; temp_ofs_i = to; eff_sel_i = es;
    bus_i = bus; ring_ct_i = ct;
    if (frm) for (int k = 0; k < 16; k++) m_eff[k] = '0;
    if (stp) begin
      sh = ref_shift(m_acc, md);
      m_data = sh;
      m_addr = 7'((int'(to) + int'(ct)) % 128);
      if (fl) m_frc = (md == 2'b11) ? {1'b0, sh[11:0]} : sh[23:11];
      if (al) m_adrs = (md == 2'b11) ? {4'b0, sh[23:12]} : bus[31:16];
      if (ew) begin
        inc = longint'($signed(sh)) >>> 4;
        m_eff[es] = m_eff[es] + inc[23:0];
      end
      m_acc = acc;
    end
    e.we = stp && tw; e.addr = m_addr; e.data = m_data; e.frc = m_frc; e.adrs = m_adrs;
    for (int k = 0; k < 16; k++) e.eff[k*24 +: 24] = m_eff[k];
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic st(logic [25:0] acc, logic [1:0] md, string tag);
    drive(1, 0, acc, md, 0, 0, 1, 0, 7'd3, 4'd0, 32'h0, 16'd0, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      if (exp_q.size() != 0) begin
        @(negedge clk_i);
        e = exp_q.pop_front();
        chk(e.tag, "we",   384'(temp_we_o),    384'(e.we));
        chk(e.tag, "addr", 384'(temp_waddr_o), 384'(e.addr));
        chk(e.tag, "data", 384'(temp_wdata_o), 384'(e.data));
        chk(e.tag, "frc",  384'(frc_o),        384'(e.frc));
        chk(e.tag, "adrs", 384'(adrs_o),       384'(e.adrs));
        chk(e.tag, "eff",  eff_regs_o,         e.eff);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin : driver
    for (int k = 0; k < 16; k++) m_eff[k] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "we",   384'(temp_we_o), 384'(0));
    chk("R1", "data", 384'(temp_wdata_o), 384'(0));
    chk("R1", "frc",  384'(frc_o), 384'(0));
    chk("R1", "adrs", 384'(adrs_o), 384'(0));
    chk("R1", "eff",  eff_regs_o, 384'(0));
    chk("R1", "addr", 384'(temp_waddr_o), 384'(0));
    rst_ni = 1'b1;
    // R2: first step uses the zero captured at reset
    st(26'd1000, 2'b00, "R2");
    st(-26'sd4000, 2'b00, "R3");
    st(26'h1FFFFFF, 2'b00, "R3");
    st(26'h2000000, 2'b00, "R3");
    st(26'h1000000, 2'b01, "R4");
    st(26'h0FFFFF0, 2'b10, "R5");
    st(26'h1FFFFFF, 2'b10, "R5");
    st(-26'sd12345, 2'b11, "R6");
    st(26'h0FEDCBA, 2'b11, "R6");
    st(26'h0000400, 2'b01, "R4");
    // R2: idle cycles with a garbage acc do not replace the captured value
    drive(0, 0, 26'h3AAAAAA, 2'b00, 1, 1, 1, 1, 7'd9, 4'd2, 32'hFFFF0000, 16'd5, "R12");
    drive(0, 0, 26'h1555555, 2'b11, 1, 1, 1, 1, 7'd9, 4'd2, 32'hFFFF0000, 16'd5, "R12");
    st(26'h0123456, 2'b10, "R2");
    // R7/R8 fraction and address latches across modes
    drive(1, 0, 26'h1ABCDEF, 2'b11, 1, 1, 0, 0, 7'd0, 4'd0, 32'hBEEF1234, 16'd0, "R7");
    drive(1, 0, -26'sd70000, 2'b00, 1, 1, 0, 0, 7'd0, 4'd0, 32'hBEEF1234, 16'd0, "R8");
    drive(1, 0, 26'h0055AA0, 2'b01, 1, 0, 0, 0, 7'd0, 4'd0, 32'h12345678, 16'd0, "R7");
    drive(1, 0, 26'h0777777, 2'b10, 0, 1, 0, 0, 7'd0, 4'd0, 32'h9ABC0000, 16'd0, "R8");
    drive(1, 0, 26'h0000000, 2'b11, 1, 1, 0, 0, 7'd0, 4'd0, 32'h55550000, 16'd0, "R8");
    // R9 ring address wrap and write-enable gating
    drive(1, 0, 26'h0001000, 2'b00, 0, 0, 1, 0, 7'd100, 4'd0, 32'h0, 16'h1234, "R9");
    drive(1, 0, 26'h0002000, 2'b00, 0, 0, 0, 0, 7'd127, 4'd0, 32'h0, 16'h0001, "R9");
    drive(1, 0, 26'h3F00000, 2'b00, 0, 0, 1, 0, 7'd127, 4'd0, 32'h0, 16'hFFFF, "R9");
    // R10 effect accumulation, positive and negative, several entries
    drive(1, 0, 26'h0100000, 2'b00, 0, 0, 0, 1, 7'd0, 4'd5, 32'h0, 16'd0, "R10");
    drive(1, 0, -26'sd160000, 2'b01, 0, 0, 0, 1, 7'd0, 4'd5, 32'h0, 16'd0, "R10");
    drive(1, 0, 26'h0000010, 2'b00, 0, 0, 0, 1, 7'd0, 4'd15, 32'h0, 16'd0, "R10");
    drive(1, 0, 26'h1FFFFFF, 2'b00, 0, 0, 0, 1, 7'd0, 4'd0, 32'h0, 16'd0, "R10");
    drive(1, 0, 26'h1FFFFFF, 2'b10, 0, 0, 0, 1, 7'd0, 4'd15, 32'h0, 16'd0, "R10");
    drive(1, 0, 26'h0, 2'b10, 0, 0, 0, 1, 7'd0, 4'd7, 32'h0, 16'd0, "R10");
    // R11 frame clear alone, then clear together with a write
    drive(0, 1, 26'h0, 2'b00, 0, 0, 0, 1, 7'd0, 4'd5, 32'h0, 16'd0, "R11");
    drive(1, 0, 26'h0200000, 2'b00, 0, 0, 0, 1, 7'd0, 4'd3, 32'h0, 16'd0, "R10");
    drive(1, 0, 26'h0080000, 2'b00, 0, 0, 0, 1, 7'd0, 4'd3, 32'h0, 16'd0, "R10");
    drive(1, 1, 26'h0, 2'b00, 0, 0, 0, 1, 7'd0, 4'd3, 32'h0, 16'd0, "R11");
    drive(1, 0, 26'h0, 2'b00, 0, 0, 0, 1, 7'd0, 4'd9, 32'h0, 16'd0, "R10");
    // R12 idle with every control high
    drive(0, 0, 26'h2345678, 2'b11, 1, 1, 1, 1, 7'd44, 4'd9, 32'hCAFE0000, 16'd9, "R12");
    drive(1, 0, 26'h0, 2'b11, 0, 0, 1, 0, 7'd1, 4'd0, 32'h0, 16'd0, "R2");
    @(negedge clk_i);
    step_i = 0; frame_i = 0; frc_ld_i = 0; adrs_ld_i = 0; temp_wr_i = 0; eff_wr_i = 0;
    repeat (4) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    summary();
  end
endmodule